// File: doc/BRIEF.md
# Paired-Page Translation Buffer Array

This block is a small, fully associative table of address translations. Each entry covers a pair of neighbouring virtual pages. It holds one page-pair tag, a per-entry page mask, an 8-bit address-space ID and a global flag. It also holds two physical halves, one for the even page and one for the odd page. Each half has its own frame number, cache attribute, dirty bit and valid bit.

A lookup port takes a full virtual address, an address-space ID and a small-pages mode input. It returns, in the same cycle, a hit flag, the index of the winning entry, a multi-hit flag and the entry's contents. Each half of the contents comes back as a packed word. A probe port takes a page number directly and reports either the matching index or a miss. The table is loaded through an indexed write port and emptied by a flush command. A register pointing at the slot after the last one written is kept for the replacement logic that sits outside this block.

Top module: `ptlb_array`

## Requirements
- R1: After a synchronous reset the table holds no live entry: lookups report no hit and probes report a miss. `nxt_idx` is 0 and `wr_err` is 0.
- R2: An entry matches when the request page number and the stored tag agree in every bit position where the entry's mask bit is 0. Bits whose mask bit is 1 are not compared.
- R3: The ID check passes when the entry's global flag is set, whatever the request ID. Otherwise it passes only when the request ID equals the stored ID.
- R4: The lookup page number is `lk_vaddr[31:11]`. Its two low bits are forced to 0 unless `small_pages` is 1.
- R5: Each half is returned packed as frame in bits [25:6], cache attribute in [5:3], dirty in [2], valid in [1] and the entry's global flag in [0]. On a lookup miss, the contents outputs are all zero.
- R6: An entry takes part in matching only if at least one of its two valid bits is set.
- R7: A probe with no matching entry drives `pr_miss` to 1 and `pr_idx` to 0. A probe with a match drives `pr_miss` to 0 and `pr_idx` to the index of that entry.
- R8: A write whose index is not below ENTRIES changes no entry and leaves `nxt_idx` unchanged. It raises `wr_err` for exactly the following cycle.
- R9: A flush clears every entry on the next clock edge and resets `nxt_idx` to 0.
- R10: When several entries match, the lowest index wins and `lk_multi` is 1. With a single match `lk_multi` is 0.
- R11: A valid write takes effect on the next clock edge. It sets `nxt_idx` to the written index plus one, wrapping from ENTRIES-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| small_pages | input | 1 | 1 KB page mode: keep the two low page-number bits on lookup |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space ID |
| lk_hit | output | 1 | Lookup found a live matching entry |
| lk_idx | output | 3 | Index of the winning entry |
| lk_multi | output | 1 | More than one entry matched |
| lk_tag | output | 21 | Tag of the winning entry (zero on miss) |
| lk_mask | output | 21 | Mask of the winning entry (zero on miss) |
| lk_even | output | 26 | Packed even half of the winning entry |
| lk_odd | output | 26 | Packed odd half of the winning entry |
| pr_vpn | input | 21 | Probe page number |
| pr_asid | input | 8 | Probe address-space ID |
| pr_miss | output | 1 | Probe found no match |
| pr_idx | output | 3 | Probe result index, 0 on miss |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Write slot |
| wr_tag | input | 21 | Tag to store |
| wr_mask | input | 21 | Page mask to store |
| wr_asid | input | 8 | ID to store |
| wr_global | input | 1 | Global flag to store |
| wr_even | input | 26 | Even half, packed as in R5 (bit 0 unused) |
| wr_odd | input | 26 | Odd half, packed as in R5 (bit 0 unused) |
| flush | input | 1 | Clear the whole table |
| wr_err | output | 1 | Previous cycle carried an out-of-range write |
| nxt_idx | output | 3 | Slot following the last one written |

## Verification
Lookups are made with an exact tag, with the ID changed, and with the two low page bits set in both page-size modes. Together these separate the tag compare, the ID compare and the low-bit forcing. A masked entry is hit with a page number that differs only under its mask, and then missed with one that differs outside it. The same entry is hit with an arbitrary ID to show that the global flag overrides the ID compare. Further cases cover an entry whose two valid bits are both clear, a pair of duplicate tags (showing the lowest index wins and the multi-hit flag rises), a write to an index beyond the table and a flush. Each of these leaves a different trace on the hit, index, contents and pointer outputs.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int VPN_W      = 21;
  localparam int ASID_W     = 8;
  localparam int FRAME_W    = 20;
  localparam int ATTR_W     = 3;
  localparam int PAGE_SHIFT = 11;
  localparam int VA_W       = VPN_W + PAGE_SHIFT;
  localparam int HALF_W     = FRAME_W + ATTR_W + 3;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic [ATTR_W-1:0]  attr;
    logic               dirty;
    logic               valid;
  } half_t;

  typedef struct packed {
    logic [VPN_W-1:0]  tag;
    logic [VPN_W-1:0]  mask;
    logic [ASID_W-1:0] asid;
    logic              glb;
    half_t             ev;
    half_t             od;
  } entry_t;

  function automatic logic [HALF_W-1:0] pack_half(input half_t h, input logic g);
    return {h.frame, h.attr, h.dirty, h.valid, g};
  endfunction

  function automatic half_t unpack_half(input logic [HALF_W-1:0] w);
    return half_t'(w[HALF_W-1:1]);
  endfunction
endpackage

// File: rtl/ptlb_store.sv
module ptlb_store
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  entry_t                   wr_ent,
  output entry_t [ENTRIES-1:0]     tab,
  output logic                     wr_err,
  output logic [IDX_W-1:0]         nxt_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic in_range;
  assign in_range = ({1'b0, wr_idx} <= {1'b0, LAST});

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= '0;
      nxt_idx <= '0;
    end else if (wr_en && in_range) begin
      tab[wr_idx] <= wr_ent;
      nxt_idx     <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_en && !in_range;
  end
endmodule

// File: rtl/ptlb_match.sv
module ptlb_match
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  entry_t [ENTRIES-1:0] tab,
  input  logic [VPN_W-1:0]     vpn,
  input  logic [ASID_W-1:0]    asid,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx,
  output logic                 multi
);
  logic [ENTRIES-1:0] m;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic live, tag_ok, id_ok;
    assign live   = tab[g].ev.valid | tab[g].od.valid;
    assign tag_ok = ((vpn ^ tab[g].tag) & ~tab[g].mask) == '0;
    assign id_ok  = tab[g].glb | (tab[g].asid == asid);
    assign m[g]   = live & tag_ok & id_ok;
  end

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (m[i]) idx = IDX_W'(i);
  end

  assign hit   = |m;
  assign multi = |(m & (m - 1'b1));
endmodule

// File: rtl/ptlb_array.sv
module ptlb_array
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              small_pages,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_multi,
  output logic [VPN_W-1:0]  lk_tag,
  output logic [VPN_W-1:0]  lk_mask,
  output logic [HALF_W-1:0] lk_even,
  output logic [HALF_W-1:0] lk_odd,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic              pr_miss,
  output logic [IDX_W-1:0]  pr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_tag,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [HALF_W-1:0] wr_even,
  input  logic [HALF_W-1:0] wr_odd,
  input  logic              flush,
  output logic              wr_err,
  output logic [IDX_W-1:0]  nxt_idx
);
  entry_t [ENTRIES-1:0] tab;
  entry_t               wr_ent;
  entry_t               sel;
  logic [VPN_W-1:0]     lk_vpn;
  logic                 pr_hit, pr_multi;
  logic [IDX_W-1:0]     pr_raw;

  assign wr_ent = '{tag: wr_tag, mask: wr_mask, asid: wr_asid, glb: wr_global,
                    ev: unpack_half(wr_even), od: unpack_half(wr_odd)};

  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_SHIFT] &
                  ~(small_pages ? VPN_W'(0) : VPN_W'(3));

  ptlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .tab(tab), .wr_err(wr_err), .nxt_idx(nxt_idx)
  );

  ptlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk (
    .tab(tab), .vpn(lk_vpn), .asid(lk_asid),
    .hit(lk_hit), .idx(lk_idx), .multi(lk_multi)
  );

  ptlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pr (
    .tab(tab), .vpn(pr_vpn), .asid(pr_asid),
    .hit(pr_hit), .idx(pr_raw), .multi(pr_multi)
  );

  assign sel     = lk_hit ? tab[lk_idx] : '0;
  assign lk_tag  = sel.tag;
  assign lk_mask = sel.mask;
  assign lk_even = pack_half(sel.ev, sel.glb);
  assign lk_odd  = pack_half(sel.od, sel.glb);

  assign pr_miss = !pr_hit;
  assign pr_idx  = pr_hit ? pr_raw : '0;

  logic unused_pr_multi;
  assign unused_pr_multi = pr_multi;
endmodule

// File: rtl/ptlb_array_chk.sv
module ptlb_array_chk
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int IDX_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_hit,
  input logic              lk_multi,
  input logic [HALF_W-1:0] lk_even,
  input logic [HALF_W-1:0] lk_odd,
  input logic              pr_miss,
  input logic [IDX_W-1:0]  pr_idx,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              flush,
  input logic              wr_err,
  input logic [IDX_W-1:0]  nxt_idx
);
  logic bad_wr;
  assign bad_wr = wr_en && ({1'b0, wr_idx} >= (IDX_W + 1)'(ENTRIES));

  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (nxt_idx == '0 && !wr_err));

  a_r6_hit_is_live: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_even[1] || lk_odd[1]));

  a_r7_miss_zero_idx: assert property (@(posedge clk) disable iff (rst)
    pr_miss |-> pr_idx == '0);

  a_r8_err_raised: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> wr_err);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(bad_wr));

  a_r8_ptr_kept: assert property (@(posedge clk) disable iff (rst)
    (bad_wr && !flush) |=> $stable(nxt_idx));

  a_r9_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!lk_hit && pr_miss && nxt_idx == '0));

  a_r10_multi_hit: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> lk_hit);
endmodule

bind ptlb_array ptlb_array_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lk_hit(lk_hit), .lk_multi(lk_multi),
  .lk_even(lk_even), .lk_odd(lk_odd), .pr_miss(pr_miss), .pr_idx(pr_idx),
  .wr_en(wr_en), .wr_idx(wr_idx), .flush(flush), .wr_err(wr_err),
  .nxt_idx(nxt_idx)
);

// File: tb/ptlb_array_tb.sv
module ptlb_array_tb_top;
  logic        clk = 1'b0;
  logic        rst, small_pages;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid, pr_asid, wr_asid;
  logic        lk_hit, lk_multi, pr_miss, wr_en, wr_global, flush, wr_err;
  logic [2:0]  lk_idx, pr_idx, wr_idx, nxt_idx;
  logic [20:0] lk_tag, lk_mask, pr_vpn, wr_tag, wr_mask;
  logic [25:0] lk_even, lk_odd, wr_even, wr_odd;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ptlb_array dut_i (
    .clk(clk), .rst(rst), .small_pages(small_pages), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_multi(lk_multi),
    .lk_tag(lk_tag), .lk_mask(lk_mask), .lk_even(lk_even), .lk_odd(lk_odd),
    .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_miss(pr_miss), .pr_idx(pr_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_even(wr_even),
    .wr_odd(wr_odd), .flush(flush), .wr_err(wr_err), .nxt_idx(nxt_idx)
  );

  function automatic logic [25:0] half(input logic [19:0] f, input logic [2:0] a,
                                       input logic d, input logic v, input logic g);
    return {f, a, d, v, g};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [20:0] t, input logic [20:0] m,
                    input logic [7:0] a, input logic g, input logic [25:0] e,
                    input logic [25:0] o);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_tag = t; wr_mask = m; wr_asid = a;
    wr_global = g; wr_even = e; wr_odd = o;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [20:0] vpn, input logic [1:0] lo, input logic [7:0] a);
    lk_vaddr = {vpn[20:2], lo, 11'h155};
    lk_asid  = a;
    #2;
  endtask

  task automatic t_reset;
    look(21'h100, 2'b00, 8'd5);
    pr_vpn = 21'h0; pr_asid = 8'd0; #1;
    chk(!lk_hit, "R1 hit", lk_hit, 0);
    chk(pr_miss, "R1 probe", pr_miss, 1);
    chk(nxt_idx == 0 && !wr_err, "R1 ptr/err", {nxt_idx, wr_err}, 0);
  endtask

  task automatic t_basic;
    wr(3'd0, 21'h100, 21'h0, 8'd5, 1'b0, half(20'h12345, 3'd3, 1, 1, 0),
       half(20'h0ABCD, 3'd5, 0, 1, 0));
    look(21'h100, 2'b00, 8'd5);
    chk(lk_hit && lk_idx == 0, "R11 write then hit", {lk_hit, lk_idx}, 4'h8);
    chk(lk_even == half(20'h12345, 3'd3, 1, 1, 0), "R5 even", lk_even,
        half(20'h12345, 3'd3, 1, 1, 0));
    chk(lk_odd == half(20'h0ABCD, 3'd5, 0, 1, 0), "R5 odd", lk_odd,
        half(20'h0ABCD, 3'd5, 0, 1, 0));
    chk(nxt_idx == 3'd1, "R11 nxt", nxt_idx, 1);
    look(21'h100, 2'b00, 8'd6);
    chk(!lk_hit && lk_even == 0, "R3 id mismatch/R5 zero", {lk_hit, lk_even}, 0);
  endtask

  task automatic t_small;
    small_pages = 1'b0;
    look(21'h100, 2'b11, 8'd5);
    chk(lk_hit, "R4 low bits forced", lk_hit, 1);
    small_pages = 1'b1;
    look(21'h100, 2'b11, 8'd5);
    chk(!lk_hit, "R4 small pages keep low bits", lk_hit, 0);
    look(21'h100, 2'b00, 8'd5);
    chk(lk_hit, "R4 small pages exact", lk_hit, 1);
    small_pages = 1'b0;
  endtask

  task automatic t_mask_global;
    wr(3'd1, 21'h400, 21'h0F0, 8'd9, 1'b1, half(20'h00777, 3'd2, 0, 0, 0),
       half(20'h00888, 3'd7, 1, 1, 0));
    look(21'h4F0, 2'b00, 8'h77);
    chk(lk_hit && lk_idx == 1, "R2 masked bits/R3 global", {lk_hit, lk_idx}, 4'h9);
    chk(lk_odd == half(20'h00888, 3'd7, 1, 1, 1) && lk_mask == 21'h0F0,
        "R5 global bit packed", lk_odd, half(20'h00888, 3'd7, 1, 1, 1));
    look(21'h500, 2'b00, 8'h77);
    chk(!lk_hit, "R2 unmasked bit differs", lk_hit, 0);
  endtask

  task automatic t_valid;
    wr(3'd2, 21'h800, 21'h0, 8'd5, 1'b0, half(20'h1, 3'd0, 1, 0, 0),
       half(20'h2, 3'd0, 1, 0, 0));
    look(21'h800, 2'b00, 8'd5);
    pr_vpn = 21'h800; pr_asid = 8'd5; #1;
    chk(!lk_hit && pr_miss, "R6 both invalid", {lk_hit, pr_miss}, 1);
  endtask

  task automatic t_probe;
    pr_vpn = 21'h100; pr_asid = 8'd5; #1;
    chk(!pr_miss && pr_idx == 0, "R7 probe idx0", {pr_miss, pr_idx}, 0);
    pr_vpn = 21'h4A0; pr_asid = 8'd0; #1;
    chk(!pr_miss && pr_idx == 1, "R7 probe idx1", {pr_miss, pr_idx}, 1);
    pr_vpn = 21'h101; pr_asid = 8'd5; #1;
    chk(pr_miss && pr_idx == 0, "R7 probe miss", {pr_miss, pr_idx}, 8);
  endtask

  task automatic t_multi;
    wr(3'd3, 21'h100, 21'h0, 8'd5, 1'b0, half(20'hCAFE0, 3'd1, 0, 1, 0),
       half(20'h0, 3'd0, 0, 0, 0));
    look(21'h100, 2'b00, 8'd5);
    chk(lk_hit && lk_idx == 0 && lk_multi, "R10 lowest wins", {lk_idx, lk_multi}, 1);
    wr(3'd0, 21'h100, 21'h0, 8'd5, 1'b0, 26'h0, 26'h0);
    look(21'h100, 2'b00, 8'd5);
    chk(lk_hit && lk_idx == 3 && !lk_multi, "R10 single match", {lk_idx, lk_multi}, 6);
    chk(lk_even == half(20'hCAFE0, 3'd1, 0, 1, 0), "R5 entry3 even", lk_even,
        half(20'hCAFE0, 3'd1, 0, 1, 0));
    wr(3'd5, 21'h2000, 21'h0, 8'd1, 1'b0, half(20'h5, 3'd0, 0, 1, 0), 26'h0);
    chk(nxt_idx == 0, "R11 pointer wraps", nxt_idx, 0);
  endtask

  task automatic t_oor;
    wr(3'd3, 21'h100, 21'h0, 8'd5, 1'b0, half(20'hCAFE0, 3'd1, 0, 1, 0), 26'h0);
    chk(nxt_idx == 4, "R11 nxt after idx3", nxt_idx, 4);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd6; wr_tag = 21'h900; wr_mask = 0; wr_asid = 8'd9;
    wr_global = 1'b1; wr_even = half(20'h9, 3'd0, 0, 1, 0); wr_odd = 0;
    @(negedge clk);
    wr_en = 1'b0;
    chk(wr_err, "R8 error raised", wr_err, 1);
    look(21'h900, 2'b00, 8'd9);
    chk(!lk_hit && nxt_idx == 4, "R8 no change", {lk_hit, nxt_idx}, 4);
    @(negedge clk);
    chk(!wr_err, "R8 error one cycle", wr_err, 0);
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    look(21'h100, 2'b00, 8'd5);
    chk(!lk_hit, "R9 flushed idx3", lk_hit, 0);
    look(21'h4F0, 2'b00, 8'd0);
    chk(!lk_hit && nxt_idx == 0, "R9 flushed global/ptr", {lk_hit, nxt_idx}, 0);
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; small_pages = 1'b0; lk_vaddr = 0; lk_asid = 0; pr_vpn = 0;
    pr_asid = 0; wr_en = 0; wr_idx = 0; wr_tag = 0; wr_mask = 0; wr_asid = 0;
    wr_global = 0; wr_even = 0; wr_odd = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_small();
    t_mask_global();
    t_valid();
    t_probe();
    t_multi();
    t_oor();
    t_flush();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule